// File: doc/BRIEF.md
# Multi-Lane Serial Memory Slave Front End

This block sits between a serial memory bus and a small internal register and memory model. It watches the serial clock, the active-low select and four data lines. It collects a one-byte command, an optional 24-bit address and optional write data, and it serializes status or memory bytes back onto one, two or four lines. All bus signals are sampled in the block's own system clock domain. Edges of the serial clock are found by comparing the current level with the level from the previous cycle, so the system clock must run at least four times faster than the serial clock.

The block holds the status register. This register has a write-enable flag, four block-protect bits and a protect-lock bit. A write to it is refused unless the write-enable flag is set. It is also refused when the lock bit is set and line 2, used as the write-protect input, is low. Line 3 is a pause input: while it is low, clock edges are ignored and the outputs float. Both of these control meanings exist only while the transfer width is single or dual. Once a quad command has been decoded, lines 2 and 3 are data lines only.

The memory side is a plain lookup. The block presents an address, and the model must return the byte at that address in the same system cycle. There is no back-pressure: the serial bus cannot be stalled, so the model must always answer.

Top module: `spi_mem_front`

## Requirements
- R1: Command, address and write-data bits are taken from line 0 on the rising serial-clock edge, most significant bit first. The command codes are: 0x06 set write-enable, 0x05 read status, 0x01 write status, 0x03 single read, 0x3B dual read and 0x6B quad read.
- R2: Output lines change only after a falling serial-clock edge. The first read bit appears on the first falling edge after the last address bit (single read) or after the last dummy clock (dual or quad read).
- R3: While select is high, all four output enables are 0. Raising select at any point abandons the command in progress, clears the bit counters and returns the width to single.
- R4: After reset, commands are ignored until select has been seen high. A frame that began with select already low has no effect and drives nothing.
- R5: In single or dual width, with select low, line 3 low forces all output enables to 0, and serial-clock edges and data are ignored until line 3 returns high. The transfer then resumes where it stopped.
- R6: Once a quad read command is decoded, line 3 low no longer pauses the transfer. Address bits are still accepted and data is still driven.
- R7: Lane use is fixed per width. Single width drives line 1 only (enable mask 0010). Dual width drives lines 1:0, with the higher bit on line 1 (mask 0011). Quad width drives lines 3:0, with the highest bit on line 3 (mask 1111).
- R8: A status write takes effect on the eighth data bit only when the write-enable flag is set. An accepted write clears the flag. A write without the flag changes nothing.
- R9: When the lock bit is set and line 2 is low at the final data bit, the status write is refused and the write-enable flag stays set.
- R10: Status layout: bit 0 is always 0, bit 1 is the write-enable flag, bits 5:2 are the block-protect bits, bit 6 is 0 and bit 7 is the lock bit. A status read repeats the byte for as long as clocks continue.
- R11: A read returns the byte from the memory model at the given address and moves on to the next address after each byte. The address wraps from all ones to zero.
- R12: Dual and quad reads insert exactly 8 dummy clocks after the address. All output enables stay 0 during those clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to sample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | Serial clock, idle low |
| cs_n | input | 1 | Active-low select |
| io_in | input | 4 | Levels seen on data lines 3..0 |
| io_out | output | 4 | Values to drive on data lines 3..0 |
| io_oe | output | 4 | Per-line output enable |
| mem_addr | output | ADDR_W | Address presented to the memory model |
| mem_rdata | input | 8 | Byte returned by the memory model for mem_addr |

## Verification
The hardest cases to reach are a pause that arrives in the middle of a byte being shifted out, and a quad transfer with line 3 held low, because both depend on where a pin changes relative to the serial-clock phase. The stimulus reaches them by stopping the serial clock while it is high. It then lowers line 3, runs several serial clocks carrying random data, and releases line 3 before the next falling edge. The same thing is done during address entry, so that ignored bits would show up as a wrong read byte. A reset taken with select already low, and a quad read cut off partway through its address, are driven directly. Random reads and status writes with random protect inputs are then mixed in.

// File: rtl/spi_mem_pkg.sv
package spi_mem_pkg;

  typedef enum logic [1:0] {
    LN_SINGLE = 2'd0,
    LN_DUAL   = 2'd1,
    LN_QUAD   = 2'd2
  } lane_e;

  typedef enum logic [2:0] {
    PH_CMD,
    PH_ADDR,
    PH_DUMMY,
    PH_RDOUT,
    PH_SROUT,
    PH_SRWR,
    PH_DONE
  } phase_e;

  localparam logic [7:0] OP_WREN  = 8'h06;
  localparam logic [7:0] OP_RDSR  = 8'h05;
  localparam logic [7:0] OP_WRSR  = 8'h01;
  localparam logic [7:0] OP_READ1 = 8'h03;
  localparam logic [7:0] OP_READ2 = 8'h3B;
  localparam logic [7:0] OP_READ4 = 8'h6B;

  function automatic logic [3:0] lane_mask(lane_e l);
    case (l)
      LN_DUAL: return 4'b0011;
      LN_QUAD: return 4'b1111;
      default: return 4'b0010;
    endcase
  endfunction

endpackage

// File: rtl/spi_sclk_edge.sv
module spi_sclk_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk,
  input  logic gate,
  output logic rise,
  output logic fall
);
  logic sclk_q;

  // History always tracks the pin, so a paused edge is lost, never replayed.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sclk_q <= 1'b0;
    else        sclk_q <= sclk;
  end

  assign rise = gate &  sclk & ~sclk_q;
  assign fall = gate & ~sclk &  sclk_q;
endmodule

// File: rtl/spi_stat_reg.sv
module spi_stat_reg (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       set_wel,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic       wp_n,
  output logic [7:0] sr
);
  logic       wel;
  logic       lock;
  logic [3:0] bp;
  logic       wr_ok;

  assign wr_ok = wr_en & wel & ~(lock & ~wp_n);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wel  <= 1'b0;
      lock <= 1'b0;
      bp   <= 4'h0;
    end else if (wr_ok) begin
      bp   <= wr_data[5:2];
      lock <= wr_data[7];
      wel  <= 1'b0;
    end else if (set_wel) begin
      wel  <= 1'b1;
    end
  end

  assign sr = {lock, 1'b0, bp, wel, 1'b0};
endmodule

// File: rtl/spi_tx_ser.sv
module spi_tx_ser
  import spi_mem_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              shift_en,
  input  lane_e             lanes,
  input  logic [BYTE_W-1:0] load_byte,
  output logic [3:0]        dq,
  output logic              byte_end,
  output logic              started
);
  localparam int POS_W = $clog2(BYTE_W);

  logic [POS_W-1:0]  pos;
  logic [POS_W-1:0]  step;
  logic [POS_W-1:0]  pos_nx;
  logic [BYTE_W-1:0] sh;
  logic [BYTE_W-1:0] src;

  always_comb begin
    case (lanes)
      LN_DUAL: step = POS_W'(2);
      LN_QUAD: step = POS_W'(4);
      default: step = POS_W'(1);
    endcase
  end

  assign pos_nx   = pos + step;
  assign src      = (pos == '0) ? load_byte : sh;
  assign byte_end = shift_en & (pos_nx == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos     <= '0;
      sh      <= '0;
      dq      <= 4'h0;
      started <= 1'b0;
    end else if (clr) begin
      pos     <= '0;
      sh      <= '0;
      dq      <= 4'h0;
      started <= 1'b0;
    end else if (shift_en) begin
      pos     <= pos_nx;
      started <= 1'b1;
      case (lanes)
        LN_DUAL: begin
          dq <= {2'b00, src[BYTE_W-1 -: 2]};
          sh <= src << 2;
        end
        LN_QUAD: begin
          dq <= src[BYTE_W-1 -: 4];
          sh <= src << 4;
        end
        default: begin
          dq <= {2'b00, src[BYTE_W-1], 1'b0};
          sh <= src << 1;
        end
      endcase
    end
  end
endmodule

// File: rtl/spi_mem_front.sv
module spi_mem_front
  import spi_mem_pkg::*;
#(
  parameter int ADDR_W     = 24,
  parameter int DUMMY_CLKS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk,
  input  logic              cs_n,
  input  logic [3:0]        io_in,
  output logic [3:0]        io_out,
  output logic [3:0]        io_oe,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [7:0]        mem_rdata
);
  localparam int CNT_MAX = (ADDR_W > DUMMY_CLKS) ? ((ADDR_W > 8) ? ADDR_W : 8)
                                                 : ((DUMMY_CLKS > 8) ? DUMMY_CLKS : 8);
  localparam int CNT_W   = $clog2(CNT_MAX);

  logic              armed;
  phase_e            phase;
  lane_e             lanes;
  logic [CNT_W-1:0]  cnt;
  logic [7:0]        cmd_sh;
  logic [7:0]        byte_nx;
  logic [ADDR_W-1:0] addr_q;
  logic              hold_act;
  logic              gate;
  logic              rise;
  logic              fall;
  logic              out_phase;
  logic              byte_end;
  logic              tx_started;
  logic [7:0]        sr;
  logic [7:0]        tx_byte;
  logic              set_wel;
  logic              sr_wr;
  logic              unused_in;

  assign unused_in = io_in[1];

  // Pause meaning of line 3 exists only outside quad width.
  assign hold_act  = ~io_in[3] & (lanes != LN_QUAD);
  assign gate      = armed & ~cs_n & ~hold_act;
  assign byte_nx   = {cmd_sh[6:0], io_in[0]};
  assign out_phase = (phase == PH_RDOUT) || (phase == PH_SROUT);
  assign set_wel   = rise && (phase == PH_CMD) && (cnt == CNT_W'(7)) && (byte_nx == OP_WREN);
  assign sr_wr     = rise && (phase == PH_SRWR) && (cnt == CNT_W'(7));
  assign tx_byte   = (phase == PH_SROUT) ? sr : mem_rdata;

  spi_sclk_edge u_edge (
    .clk  (clk),
    .rst_n(rst_n),
    .sclk (sclk),
    .gate (gate),
    .rise (rise),
    .fall (fall)
  );

  spi_stat_reg u_sr (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_wel(set_wel),
    .wr_en  (sr_wr),
    .wr_data(byte_nx),
    .wp_n   (io_in[2]),
    .sr     (sr)
  );

  spi_tx_ser #(.BYTE_W(8)) u_tx (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (cs_n),
    .shift_en (fall & out_phase),
    .lanes    (lanes),
    .load_byte(tx_byte),
    .dq       (io_out),
    .byte_end (byte_end),
    .started  (tx_started)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed  <= 1'b0;
      phase  <= PH_CMD;
      lanes  <= LN_SINGLE;
      cnt    <= '0;
      cmd_sh <= 8'h00;
      addr_q <= '0;
    end else if (cs_n) begin
      armed  <= 1'b1;
      phase  <= PH_CMD;
      lanes  <= LN_SINGLE;
      cnt    <= '0;
    end else if (rise) begin
      case (phase)
        PH_CMD: begin
          cmd_sh <= byte_nx;
          if (cnt == CNT_W'(7)) begin
            cnt <= '0;
            case (byte_nx)
              OP_WREN:  phase <= PH_DONE;
              OP_RDSR:  phase <= PH_SROUT;
              OP_WRSR:  phase <= PH_SRWR;
              OP_READ1: phase <= PH_ADDR;
              OP_READ2: begin phase <= PH_ADDR; lanes <= LN_DUAL; end
              OP_READ4: begin phase <= PH_ADDR; lanes <= LN_QUAD; end
              default:  phase <= PH_DONE;
            endcase
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        PH_ADDR: begin
          addr_q <= {addr_q[ADDR_W-2:0], io_in[0]};
          if (cnt == CNT_W'(ADDR_W-1)) begin
            cnt   <= '0;
            phase <= (lanes == LN_SINGLE) ? PH_RDOUT : PH_DUMMY;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        PH_DUMMY: begin
          if (cnt == CNT_W'(DUMMY_CLKS-1)) begin
            cnt   <= '0;
            phase <= PH_RDOUT;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        PH_SRWR: begin
          cmd_sh <= byte_nx;
          if (cnt == CNT_W'(7)) phase <= PH_DONE;
          else                  cnt   <= cnt + 1'b1;
        end
        default: ;
      endcase
    end else if (byte_end && phase == PH_RDOUT) begin
      addr_q <= addr_q + 1'b1;
    end
  end

  assign mem_addr = addr_q;
  assign io_oe    = (tx_started && out_phase && !cs_n && !hold_act) ? lane_mask(lanes) : 4'b0000;

endmodule

// File: rtl/spi_mem_front_chk.sv
module spi_mem_front_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cs_n,
  input logic [3:0] io_in,
  input logic [3:0] io_out,
  input logic [3:0] io_oe,
  input logic       fall,
  input logic [1:0] lanes,
  input logic [7:0] sr
);
  a_r3_deselect_float: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> io_oe == 4'b0000);

  a_r2_change_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(fall) && !$past(cs_n)) |-> $stable(io_out));

  a_r5_pause_float: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && !io_in[3] && lanes != 2'd2) |-> io_oe == 4'b0000);

  a_r7_lane_mask: assert property (@(posedge clk) disable iff (!rst_n)
    io_oe == 4'b0000 || (lanes == 2'd0 && io_oe == 4'b0010) ||
    (lanes == 2'd1 && io_oe == 4'b0011) || (lanes == 2'd2 && io_oe == 4'b1111));

  a_r8_needs_wel: assert property (@(posedge clk) disable iff (!rst_n)
    !sr[1] |=> $stable(sr[7:2]));

  a_r9_wp_lock: assert property (@(posedge clk) disable iff (!rst_n)
    (sr[7] && !io_in[2]) |=> $stable(sr[7:2]));

  a_r10_fixed_zero: assert property (@(posedge clk) disable iff (!rst_n)
    sr[0] == 1'b0 && sr[6] == 1'b0);
endmodule

bind spi_mem_front spi_mem_front_chk u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .cs_n  (cs_n),
  .io_in (io_in),
  .io_out(io_out),
  .io_oe (io_oe),
  .fall  (fall),
  .lanes (lanes),
  .sr    (sr)
);

// File: tb/spi_mem_front_bench.sv
module spi_mem_front_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sclk = 1'b0;
  logic        cs_n = 1'b0;
  logic [3:0]  io_in = 4'b1100;
  logic [3:0]  io_out;
  logic [3:0]  io_oe;
  logic [23:0] mem_addr;
  logic [7:0]  mem_rdata;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  bit       m_wel = 0;
  bit       m_lock = 0;
  bit [3:0] m_bp = 0;
  logic [3:0] last_oe;

  always #10 clk = ~clk;

  function automatic logic [7:0] mem_fn(input logic [23:0] a);
    return a[7:0] ^ a[15:8] ^ a[23:16] ^ 8'hA5;
  endfunction

  assign mem_rdata = mem_fn(mem_addr);

  spi_mem_front u_spi_mem_front (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n),
    .io_in(io_in), .io_out(io_out), .io_oe(io_oe),
    .mem_addr(mem_addr), .mem_rdata(mem_rdata)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  task automatic tick(input logic [3:0] din, output logic [3:0] dq, output logic [3:0] oe);
    @(negedge clk); sclk = 1'b0; io_in = din;
    @(negedge clk); @(negedge clk);
    dq = io_out; oe = io_oe;
    sclk = 1'b1;
    @(negedge clk); @(negedge clk);
  endtask

  task automatic send_byte(input logic [7:0] b, input bit wp);
    logic [3:0] dq, oe;
    for (int i = 7; i >= 0; i--) tick({1'b1, wp, 1'b0, b[i]}, dq, oe);
  endtask

  task automatic sel();
    @(negedge clk); sclk = 1'b0; cs_n = 1'b1; io_in = 4'b1100;
    repeat (3) @(negedge clk);
    cs_n = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic desel();
    @(negedge clk); cs_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  // Pause with line 3 while sclk is high, clock garbage, then release.
  task automatic pause(input bit out_side);
    @(negedge clk); io_in[3] = 1'b0;
    repeat (2) @(negedge clk);
    if (out_side) chk("R5 pause floats outputs", io_oe, 4'b0000);
    for (int k = 0; k < 3; k++) begin
      sclk = 1'b0; io_in[0] = 1'($urandom);
      repeat (2) @(negedge clk);
      sclk = 1'b1;
      repeat (2) @(negedge clk);
    end
    io_in[3] = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic read_sr(output logic [7:0] v);
    logic [3:0] dq, oe;
    sel();
    send_byte(8'h05, 1'b1);
    v = 8'h00;
    for (int i = 0; i < 8; i++) begin
      tick(4'b1100, dq, oe);
      if (i == 0) last_oe = oe;
      v = {v[6:0], dq[1]};
    end
    desel();
  endtask

  task automatic check_sr(input string req);
    logic [7:0] v;
    read_sr(v);
    chk(req, v, {m_lock, 1'b0, m_bp, m_wel, 1'b0});
  endtask

  task automatic wren();
    sel(); send_byte(8'h06, 1'b1); desel();
    m_wel = 1;
  endtask

  task automatic wrsr(input logic [7:0] d, input bit wp);
    sel(); send_byte(8'h01, 1'b1); send_byte(d, wp); desel();
    if (m_wel && !(m_lock && !wp)) begin
      m_bp = d[5:2]; m_lock = d[7]; m_wel = 0;
    end
  endtask

  // mode 0 single, 1 dual, 2 quad
  task automatic do_read(input int mode, input logic [23:0] a, input int n,
                         input bit q_hold_lo, input bit pauses, input string req);
    logic [3:0] dq, oe;
    logic [7:0] v;
    logic [7:0] op;
    bit bad;
    int per;
    op  = (mode == 0) ? 8'h03 : (mode == 1) ? 8'h3B : 8'h6B;
    per = (mode == 0) ? 8 : (mode == 1) ? 4 : 2;
    sel();
    send_byte(op, 1'b1);
    for (int i = 23; i >= 0; i--) begin
      tick({~q_hold_lo, 1'b1, 1'b0, a[i]}, dq, oe);
      if (pauses && i == 12) pause(1'b0);
    end
    if (mode == 0) begin
      @(negedge clk);
      chk("R2 nothing driven before first fall", io_oe, 4'b0000);
    end else begin
      bad = 0;
      for (int i = 0; i < 8; i++) begin
        tick(4'b1100, dq, oe);
        if (oe != 4'b0000) bad = 1;
      end
      chk("R12 dummy clocks silent", 32'(bad), 32'd0);
    end
    for (int b = 0; b < n; b++) begin
      v = 8'h00;
      for (int k = 0; k < per; k++) begin
        tick(4'b1100, dq, oe);
        if (b == 0 && k == 0)
          chk("R7 enable mask", oe, (mode == 0) ? 4'b0010 : (mode == 1) ? 4'b0011 : 4'b1111);
        case (mode)
          0:       v = {v[6:0], dq[1]};
          1:       v = {v[5:0], dq[1:0]};
          default: v = {v[3:0], dq};
        endcase
        if (pauses && b == 0 && k == per / 2 - 1) pause(1'b1);
      end
      chk(req, v, mem_fn(24'(a + 24'(b))));
    end
    desel();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [3:0] dq, oe;
    logic [7:0] v;
    bit bad;
    void'($urandom(32'd7321));
    // Reset with select already low: frame must be ignored (R4).
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R3 reset outputs floating", io_oe, 4'b0000);
    send_byte(8'h06, 1'b1);
    send_byte(8'h05, 1'b1);
    bad = 0;
    for (int i = 0; i < 8; i++) begin
      tick(4'b1100, dq, oe);
      if (oe != 4'b0000) bad = 1;
    end
    chk("R4 unarmed frame drives nothing", 32'(bad), 32'd0);
    desel();
    check_sr("R4 unarmed write-enable ignored");
    chk("R7 status read uses line 1", last_oe, 4'b0010);

    // Status register rules.
    wren();
    check_sr("R10 write-enable visible in bit 1");
    wrsr(8'b0011_1100, 1'b1);
    check_sr("R8 accepted write clears flag");
    wrsr(8'b0000_0000, 1'b1);
    check_sr("R8 write without flag ignored");
    wren();
    wrsr(8'b1001_0100, 1'b1);
    check_sr("R10 lock and protect bits");
    wren();
    wrsr(8'b0000_0000, 1'b0);
    check_sr("R9 locked write refused, flag kept");
    wrsr(8'b0000_1000, 1'b1);
    check_sr("R9 write accepted with line 2 high");

    // Reads.
    do_read(0, 24'h000000, 3, 0, 0, "R1 single read");
    do_read(0, 24'hFFFFFF, 2, 0, 0, "R11 address wrap");
    do_read(1, 24'h12A5F0, 3, 0, 0, "R7 dual read");
    do_read(2, 24'h5C0301, 3, 0, 0, "R7 quad read");
    do_read(2, 24'h0F0F0E, 2, 1, 0, "R6 quad ignores line 3");
    do_read(0, 24'h3C3C3C, 2, 0, 1, "R5 single paused resumes");
    do_read(1, 24'hA00077, 2, 0, 1, "R5 dual paused resumes");

    // Abort a quad read mid-address.
    sel();
    send_byte(8'h6B, 1'b1);
    for (int i = 0; i < 10; i++) tick(4'b1101, dq, oe);
    desel();
    chk("R3 deselected floats", io_oe, 4'b0000);
    check_sr("R3 status after abort");
    chk("R3 width back to single", last_oe, 4'b0010);

    // Random mix.
    for (int it = 0; it < 30; it++) begin
      int kind;
      kind = int'($urandom_range(0, 3));
      if (kind == 0) begin
        wren();
        wrsr(8'($urandom), 1'($urandom));
        check_sr("R8 random status write");
      end else begin
        do_read(int'($urandom_range(0, 2)), 24'($urandom), int'($urandom_range(1, 3)),
                0, 0, "R11 random read");
      end
    end
    finish_run();
  end
endmodule